// File: doc/BRIEF.md
# Store Buffer with Page-Offset Load Disambiguation

This block holds retired stores in program order and writes them into a cache one at a time. It sits between the store side of a core and the cache. Each load is compared with the stores that are already buffered. The comparison uses only the low page-offset bits of the address. A load with no overlap reads the cache at once. A load with any overlap waits until every overlapping older store has reached the cache, and then reads the cache. Data is never forwarded from the buffer to a load.

Because the upper address bits are not compared, a load and a store in different pages that share an offset range are treated as dependent. The block counts the stall cycles that come only from such false aliases, so their cost can be measured.

Loads go through a two-state controller. In `LD_IDLE` the controller accepts a load. A load with no overlap takes the *accept-clear* transition: it stays in `LD_IDLE` and issues the cache read in the same cycle. A load that overlaps takes the *accept-blocked* transition into `LD_STALL`. While blockers remain, the controller takes the *still-blocked* transition and stays in `LD_STALL`. In the first cycle with no blocker left, it takes the *released* transition: it issues the read and returns to `LD_IDLE`.

Top module: `sbuf_top`

## Requirements
- R1: After reset the buffer is empty, `st_ready` and `ld_ready` are high, `cw_valid` and `ld_rsp_valid` are low, and `alias_stall_cnt` is zero.
- R2: Buffered stores leave on the cache write port in the order they were accepted. At most one store leaves per cycle, and only in a cycle where `cw_ready` is high. Each store keeps its address, size and data.
- R3: The buffer holds DEPTH stores (8 by default). `st_ready` is low while it is full. A store offered while `st_ready` is low is not taken and never reaches the cache.
- R4: Access size is encoded as 0=1, 1=2, 2=4 and 3=8 bytes. An access covers the bytes [offset, offset+size), where offset is address bits [PAGE_BITS-1:0] (12 by default) and the end is computed one bit wider, so nothing wraps. A load that overlaps no buffered store asserts `cr_valid` in its accept cycle, and `ld_rsp_valid` follows one cycle later.
- R5: A partial byte overlap counts as a conflict. An 8-byte store at offset 0x008 blocks an 8-byte load at offset 0x00c. Ranges that only touch do not conflict: an 8-byte store at 0x010 does not block a load at 0x008 or a 4-byte load at 0x004.
- R6: Address bits above the page offset are ignored. An 8-byte load at 0xf00c stalls behind an 8-byte store at 0xe008.
- R7: A blocked load issues its cache read in the first cycle after the cycle in which its last blocking store was written to the cache. Its response follows one cycle after the read.
- R8: A load is checked only against the stores held at its accept cycle. Stores accepted later never delay it, so its data reflects the older stores only.
- R9: The cache read port supplies 8 bytes, with byte i on lane [8i+7:8i] being address+i. The load response carries the low 2^size bytes of that word, with the rest zero. Store data uses the same lane layout.
- R10: `alias_stall_cnt` counts the stall cycles in which at least one blocker remains and every remaining blocker differs from the load in its upper address bits. It saturates at its all-ones value.
- R11: `ld_ready` is high only in `LD_IDLE`. Only one load is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | AW | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | 64 | Store data, byte lanes from bit 0 |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Controller can take a load |
| ld_addr | input | AW | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_rsp_valid | output | 1 | Load data valid |
| ld_rsp_data | output | 64 | Load data, zero-extended |
| cw_valid | output | 1 | Cache write request |
| cw_ready | input | 1 | Cache accepts the write |
| cw_addr | output | AW | Cache write address |
| cw_size | output | 2 | Cache write size code |
| cw_data | output | 64 | Cache write data |
| cr_valid | output | 1 | Cache read issued this cycle |
| cr_addr | output | AW | Cache read address |
| cr_size | output | 2 | Cache read size code |
| cr_data | input | 64 | Cache read data, same cycle |
| alias_stall_cnt | output | CNT_W | Saturating false-alias stall cycle count |

## Verification
A wrong queue pointer or a lost valid bit shows up on the cache write port within one drain. It appears as a store out of order, repeated, or missing. A corrupted blocker mask shows up as a load response that comes one or more cycles early with stale data, or that comes late or never. Response timing is therefore measured against the cycle stamp of each drain. A miscounted false-alias stall shows at once as a difference between `alias_stall_cnt` and the measured load latency minus two.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    localparam int DATA_W = 64;

    typedef enum logic {
        LD_IDLE  = 1'b0,
        LD_STALL = 1'b1
    } ld_state_e;

    // byte-lane mask for a size code (0:1B 1:2B 2:4B 3:8B)
    function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sz);
        logic [DATA_W-1:0] m;
        unique case (sz)
            2'd0: m = 64'h0000_0000_0000_00ff;
            2'd1: m = 64'h0000_0000_0000_ffff;
            2'd2: m = 64'h0000_0000_ffff_ffff;
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sbuf_queue.sv
module sbuf_queue
    import sbuf_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enq_valid,
    output logic                 enq_ready,
    input  logic [AW-1:0]        enq_addr,
    input  logic [1:0]           enq_size,
    input  logic [DATA_W-1:0]    enq_data,
    output logic                 deq_valid,
    input  logic                 deq_ready,
    output logic [AW-1:0]        deq_addr,
    output logic [1:0]           deq_size,
    output logic [DATA_W-1:0]    deq_data,
    output logic [DEPTH-1:0]     ent_valid,
    output logic [DEPTH*AW-1:0]  ent_addr,
    output logic [DEPTH*2-1:0]   ent_size,
    output logic [DEPTH-1:0]     deq_onehot
);
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW   = $clog2(DEPTH + 1);

    logic [AW-1:0]     addr_q [DEPTH];
    logic [1:0]        size_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  valid_q;
    logic [IDXW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]     count_q;
    logic              enq_fire, deq_fire;

    assign enq_ready = (count_q != CW'(DEPTH));
    assign deq_valid = (count_q != '0);
    assign enq_fire  = enq_valid && enq_ready;
    assign deq_fire  = deq_valid && deq_ready;

    assign deq_addr = addr_q[rd_ptr];
    assign deq_size = size_q[rd_ptr];
    assign deq_data = data_q[rd_ptr];

    function automatic logic [IDXW-1:0] bump(input logic [IDXW-1:0] p);
        return (p == IDXW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
            valid_q <= '0;
        end else begin
            if (enq_fire) begin
                wr_ptr          <= bump(wr_ptr);
                valid_q[wr_ptr] <= 1'b1;
            end
            if (deq_fire) begin
                rd_ptr          <= bump(rd_ptr);
                valid_q[rd_ptr] <= 1'b0;
            end
            unique case ({enq_fire, deq_fire})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (enq_fire) begin
            addr_q[wr_ptr] <= enq_addr;
            size_q[wr_ptr] <= enq_size;
            data_q[wr_ptr] <= enq_data;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign ent_addr[g*AW +: AW] = addr_q[g];
        assign ent_size[g*2 +: 2]   = size_q[g];
        assign deq_onehot[g]        = deq_fire && (rd_ptr == IDXW'(g));
    end
    assign ent_valid = valid_q;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    // R2
    drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_fire && !enq_fire) |=> (count_q == $past(count_q) - 1'b1));

    // R3
    refuse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !enq_ready && !deq_fire) |=> $stable(count_q));

endmodule

// File: rtl/sbuf_alias_chk.sv
module sbuf_alias_chk #(
    parameter int AW        = 32,
    parameter int DEPTH     = 8,
    parameter int PAGE_BITS = 12
) (
    input  logic [DEPTH-1:0]    ent_valid,
    input  logic [DEPTH*AW-1:0] ent_addr,
    input  logic [DEPTH*2-1:0]  ent_size,
    input  logic [AW-1:0]       ld_addr,
    input  logic [1:0]          ld_size,
    output logic [DEPTH-1:0]    hit_mask,
    output logic [DEPTH-1:0]    true_mask
);
    localparam int OW = PAGE_BITS + 1;
    localparam int UW = AW - PAGE_BITS;

    logic [OW-1:0] l_lo, l_hi;

    assign l_lo = {1'b0, ld_addr[PAGE_BITS-1:0]};
    assign l_hi = l_lo + (OW'(1) << ld_size);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic [OW-1:0] e_lo, e_hi;
        logic          overlap;
        assign e_lo    = {1'b0, ent_addr[g*AW +: PAGE_BITS]};
        assign e_hi    = e_lo + (OW'(1) << ent_size[g*2 +: 2]);
        assign overlap = (e_lo < l_hi) && (l_lo < e_hi);
        assign hit_mask[g]  = ent_valid[g] && overlap;
        assign true_mask[g] = hit_mask[g] &&
                              (ent_addr[g*AW + PAGE_BITS +: UW] == ld_addr[AW-1:PAGE_BITS]);
    end

endmodule

// File: rtl/sbuf_load_ctl.sv
module sbuf_load_ctl
    import sbuf_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [AW-1:0]     ld_addr,
    input  logic [1:0]        ld_size,
    input  logic [DEPTH-1:0]  hit_mask,
    input  logic [DEPTH-1:0]  true_mask,
    input  logic [DEPTH-1:0]  drain_onehot,
    output logic              cr_valid,
    output logic [AW-1:0]     cr_addr,
    output logic [1:0]        cr_size,
    input  logic [DATA_W-1:0] cr_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [CNT_W-1:0]  fa_cnt
);
    ld_state_e        state_q, state_d;
    logic [AW-1:0]    hold_addr;
    logic [1:0]       hold_size;
    logic [DEPTH-1:0] mask_q, true_q;
    logic             accept;
    logic             fa_cycle;

    assign accept = ld_valid && ld_ready;

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:  if (accept && (hit_mask != '0)) state_d = LD_STALL;
            LD_STALL: if (mask_q == '0)               state_d = LD_IDLE;
        endcase
    end

    // output process
    always_comb begin
        ld_ready = 1'b0;
        cr_valid = 1'b0;
        cr_addr  = ld_addr;
        cr_size  = ld_size;
        fa_cycle = 1'b0;
        unique case (state_q)
            LD_IDLE: begin
                ld_ready = 1'b1;
                cr_valid = ld_valid && (hit_mask == '0);
            end
            LD_STALL: begin
                cr_addr  = hold_addr;
                cr_size  = hold_size;
                cr_valid = (mask_q == '0);
                fa_cycle = (mask_q != '0) && ((mask_q & true_q) == '0);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= LD_IDLE;
            hold_addr <= '0;
            hold_size <= '0;
            mask_q    <= '0;
            true_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            fa_cnt    <= '0;
        end else begin
            state_q   <= state_d;
            rsp_valid <= cr_valid;
            if (cr_valid) rsp_data <= cr_data & lane_mask(cr_size);
            if (accept) begin
                hold_addr <= ld_addr;
                hold_size <= ld_size;
                mask_q    <= hit_mask & ~drain_onehot;
                true_q    <= true_mask & ~drain_onehot;
            end else begin
                mask_q    <= mask_q & ~drain_onehot;
                true_q    <= true_q & ~drain_onehot;
            end
            if (fa_cycle && (fa_cnt != '1)) fa_cnt <= fa_cnt + 1'b1;
        end
    end

    // R7
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_valid |=> rsp_valid);

    // R4
    rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cr_valid));

    // R8
    mask_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_STALL && $past(state_q) == LD_STALL) |->
            ((mask_q & ~$past(mask_q)) == '0));

    // R10
    fa_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (fa_cnt >= $past(fa_cnt)));

endmodule

// File: rtl/sbuf_top.sv
module sbuf_top
    import sbuf_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DEPTH     = 8,
    parameter int PAGE_BITS = 12,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [AW-1:0]     st_addr,
    input  logic [1:0]        st_size,
    input  logic [63:0]       st_data,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [AW-1:0]     ld_addr,
    input  logic [1:0]        ld_size,
    output logic              ld_rsp_valid,
    output logic [63:0]       ld_rsp_data,
    output logic              cw_valid,
    input  logic              cw_ready,
    output logic [AW-1:0]     cw_addr,
    output logic [1:0]        cw_size,
    output logic [63:0]       cw_data,
    output logic              cr_valid,
    output logic [AW-1:0]     cr_addr,
    output logic [1:0]        cr_size,
    input  logic [63:0]       cr_data,
    output logic [CNT_W-1:0]  alias_stall_cnt
);
    logic [DEPTH-1:0]    ent_valid, deq_onehot, hit_mask, true_mask;
    logic [DEPTH*AW-1:0] ent_addr;
    logic [DEPTH*2-1:0]  ent_size;

    sbuf_queue #(.AW(AW), .DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .enq_valid  (st_valid),
        .enq_ready  (st_ready),
        .enq_addr   (st_addr),
        .enq_size   (st_size),
        .enq_data   (st_data),
        .deq_valid  (cw_valid),
        .deq_ready  (cw_ready),
        .deq_addr   (cw_addr),
        .deq_size   (cw_size),
        .deq_data   (cw_data),
        .ent_valid  (ent_valid),
        .ent_addr   (ent_addr),
        .ent_size   (ent_size),
        .deq_onehot (deq_onehot)
    );

    sbuf_alias_chk #(.AW(AW), .DEPTH(DEPTH), .PAGE_BITS(PAGE_BITS)) u_alias (
        .ent_valid (ent_valid),
        .ent_addr  (ent_addr),
        .ent_size  (ent_size),
        .ld_addr   (ld_addr),
        .ld_size   (ld_size),
        .hit_mask  (hit_mask),
        .true_mask (true_mask)
    );

    sbuf_load_ctl #(.AW(AW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_load (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_valid     (ld_valid),
        .ld_ready     (ld_ready),
        .ld_addr      (ld_addr),
        .ld_size      (ld_size),
        .hit_mask     (hit_mask),
        .true_mask    (true_mask),
        .drain_onehot (deq_onehot),
        .cr_valid     (cr_valid),
        .cr_addr      (cr_addr),
        .cr_size      (cr_size),
        .cr_data      (cr_data),
        .rsp_valid    (ld_rsp_valid),
        .rsp_data     (ld_rsp_data),
        .fa_cnt       (alias_stall_cnt)
    );

    // R4
    hit_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_mask & ~ent_valid) == '0) && ((true_mask & ~hit_mask) == '0));

    // R2
    one_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(deq_onehot) && ((deq_onehot != '0) == (cw_valid && cw_ready)));

endmodule

// File: tb/test_sbuf_top.sv
`timescale 1ns/1ps
module test_sbuf_top;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0, ld_valid = 1'b0, cw_ready = 1'b0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [1:0]  st_size = '0, ld_size = '0;
    logic [63:0] st_data = '0;
    logic        st_ready, ld_ready, ld_rsp_valid, cw_valid, cr_valid;
    logic [63:0] ld_rsp_data, cw_data, cr_data;
    logic [AW-1:0] cw_addr, cr_addr;
    logic [1:0]  cw_size, cr_size;
    logic [3:0]  alias_stall_cnt;

    int checks = 0, errors = 0, cyc = 0, dn = 0;
    bit done = 0, rand_mode = 0;
    logic [7:0]  cmem [65536];
    logic [7:0]  refm [65536];
    logic [31:0] dlog_addr [1024];
    int          dlog_cyc  [1024];

    always #2.5 clk = ~clk;

    sbuf_top #(.CNT_W(4)) i_sbuf_top (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_size(st_size), .st_data(st_data),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_size(ld_size),
        .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
        .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_addr(cw_addr),
        .cw_size(cw_size), .cw_data(cw_data),
        .cr_valid(cr_valid), .cr_addr(cr_addr), .cr_size(cr_size), .cr_data(cr_data),
        .alias_stall_cnt(alias_stall_cnt)
    );

    // cache model: written on each drain handshake, read combinationally
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 65536; i++) cmem[i] <= 8'h00;
        end else if (cw_valid && cw_ready) begin
            for (int i = 0; i < 8; i++)
                if (i < (1 << cw_size)) cmem[16'(cw_addr[15:0] + 16'(i))] <= cw_data[8*i +: 8];
            dlog_addr[dn % 1024] <= cw_addr;
            dlog_cyc[dn % 1024]  <= cyc;
            dn <= dn + 1;
        end
    end

    always_comb begin
        for (int i = 0; i < 8; i++) cr_data[8*i +: 8] = cmem[16'(cr_addr[15:0] + 16'(i))];
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_load(input logic [31:0] a, input logic [1:0] s);
        logic [63:0] v = '0;
        for (int i = 0; i < 8; i++)
            if (i < (1 << s)) v[8*i +: 8] = refm[16'(a[15:0] + 16'(i))];
        return v;
    endfunction

    task automatic do_store(input logic [31:0] a, input logic [1:0] s, input logic [63:0] d);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_size = s; st_data = d;
        while (!st_ready) @(negedge clk);
        @(posedge clk);
        #1 st_valid = 1'b0;
        for (int i = 0; i < 8; i++)
            if (i < (1 << s)) refm[16'(a[15:0] + 16'(i))] = d[8*i +: 8];
    endtask

    task automatic do_load(input logic [31:0] a, input logic [1:0] s,
                           output int lat, output logic [63:0] d, output int rcyc);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_size = s;
        while (!ld_ready) @(negedge clk);
        @(posedge clk);
        #1 ld_valid = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!ld_rsp_valid && lat < 400);
        d = ld_rsp_data;
        rcyc = cyc;
    endtask

    task automatic drain_all();
        cw_ready = 1'b1;
        @(negedge clk);
        while (cw_valid) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat, rc, c0, d0;
        logic [63:0] d, e;
        void'($urandom(32'd20240601));
        for (int i = 0; i < 65536; i++) refm[i] = 8'h00;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(st_ready && ld_ready && !cw_valid && !ld_rsp_valid, "R1 handshakes",
            {st_ready, ld_ready, cw_valid, ld_rsp_valid}, 4'b1100);
        chk(alias_stall_cnt == 0, "R1 counter", alias_stall_cnt, 0);

        // R6 false alias across pages, R10 counter
        cw_ready = 1'b0;
        do_store(32'he008, 2'd3, 64'h1122334455667788);
        e = exp_load(32'hf00c, 2'd3);
        c0 = alias_stall_cnt;
        fork
            do_load(32'hf00c, 2'd3, lat, d, rc);
            begin repeat (4) @(negedge clk); cw_ready = 1'b1; end
        join
        chk(lat >= 3, "R6 stall across pages", lat, 3);
        chk(d == e, "R6 data", d, e);
        chk(alias_stall_cnt == 4'(c0 + lat - 2), "R10 false alias count", alias_stall_cnt, c0 + lat - 2);
        drain_all();

        // R5 partial overlap same page, no false-alias count
        cw_ready = 1'b0;
        do_store(32'h2008, 2'd3, 64'hcafef00ddeadbeef);
        e = exp_load(32'h200c, 2'd3);
        c0 = alias_stall_cnt;
        fork
            do_load(32'h200c, 2'd3, lat, d, rc);
            begin repeat (3) @(negedge clk); cw_ready = 1'b1; end
        join
        chk(lat >= 3, "R5 partial overlap stalls", lat, 3);
        chk(d == e, "R5 data after drain", d, e);
        chk(alias_stall_cnt == 4'(c0), "R10 true alias not counted", alias_stall_cnt, c0);
        drain_all();

        // R4/R5 no conflict loads with a store held
        cw_ready = 1'b0;
        do_store(32'h0010, 2'd3, 64'h0f0e0d0c0b0a0908);
        do_load(32'h0004, 2'd2, lat, d, rc);
        chk(lat == 1, "R4 no-conflict load immediate", lat, 1);
        chk(d == exp_load(32'h0004, 2'd2), "R9 data zero-extended", d, exp_load(32'h0004, 2'd2));
        do_load(32'h0008, 2'd3, lat, d, rc);
        chk(lat == 1, "R5 adjacent range no stall", lat, 1);
        drain_all();

        // R4 byte granularity
        cw_ready = 1'b0;
        do_store(32'h0007, 2'd0, 64'h00000000000000a5);
        do_load(32'h0006, 2'd0, lat, d, rc);
        chk(lat == 1, "R4 neighbour byte no stall", lat, 1);
        e = exp_load(32'h0007, 2'd0);
        fork
            do_load(32'h0007, 2'd0, lat, d, rc);
            begin repeat (2) @(negedge clk); cw_ready = 1'b1; end
        join
        chk(lat >= 3, "R4 same byte stalls", lat, 3);
        chk(d == e, "R9 byte data", d, e);
        drain_all();

        // R8 and R7: later store to same address does not delay the load
        cw_ready = 1'b0;
        do_store(32'h3000, 2'd3, 64'h00000000aaaaaaaa);
        e = exp_load(32'h3000, 2'd3);
        d0 = dn;
        fork
            do_load(32'h3000, 2'd3, lat, d, rc);
            begin
                repeat (2) @(negedge clk);
                do_store(32'h3000, 2'd3, 64'h00000000bbbbbbbb);
                repeat (2) @(negedge clk);
                cw_ready = 1'b1;
            end
        join
        chk(d == e, "R8 later store not seen", d, e);
        chk(rc == dlog_cyc[d0 % 1024] + 2, "R7 response two cycles after drain",
            rc, dlog_cyc[d0 % 1024] + 2);
        drain_all();

        // R3 capacity and refusal, R2 order
        cw_ready = 1'b0;
        d0 = dn;
        for (int i = 0; i < 8; i++) do_store(32'h0400 + 32'(i * 8), 2'd3, 64'(i + 100));
        @(negedge clk);
        chk(!st_ready, "R3 full", st_ready, 0);
        st_valid = 1'b1; st_addr = 32'h0600; st_size = 2'd3; st_data = 64'hdead;
        repeat (3) @(negedge clk);
        st_valid = 1'b0;
        drain_all();
        chk(dn - d0 == 8, "R3 refused store dropped", dn - d0, 8);
        for (int i = 0; i < 8; i++)
            chk(dlog_addr[(d0 + i) % 1024] == 32'h0400 + 32'(i * 8), "R2 order",
                dlog_addr[(d0 + i) % 1024], 32'h0400 + 32'(i * 8));
        do_load(32'h0600, 2'd3, lat, d, rc);
        chk(d == 64'h0, "R3 refused data absent", d, 0);
        do_load(32'h0418, 2'd3, lat, d, rc);
        chk(d == 64'd103, "R2 data kept", d, 103);

        // random mix: R9 data checks
        rand_mode = 1'b1;
        fork
            while (rand_mode) begin @(negedge clk); cw_ready = 1'($urandom % 2); end
        join_none
        for (int it = 0; it < 60; it++) begin
            int n = $urandom % 6;
            for (int k = 0; k < n; k++) begin
                logic [1:0] s = 2'($urandom % 4);
                logic [31:0] a = (32'($urandom % 4) << 12) | (32'($urandom % 64) & ~((32'd1 << s) - 1));
                do_store(a, s, {$urandom, $urandom});
            end
            begin
                logic [1:0] s = 2'($urandom % 4);
                logic [31:0] a = (32'($urandom % 4) << 12) | (32'($urandom % 64) & ~((32'd1 << s) - 1));
                e = exp_load(a, s);
                do_load(a, s, lat, d, rc);
                chk(d == e, "R9 random load data", d, e);
            end
        end
        rand_mode = 1'b0;
        repeat (2) @(negedge clk);
        drain_all();

        // R10 saturation
        cw_ready = 1'b0;
        do_store(32'h0100, 2'd3, 64'h5);
        fork
            do_load(32'h1100, 2'd3, lat, d, rc);
            begin repeat (20) @(negedge clk); cw_ready = 1'b1; end
        join
        chk(alias_stall_cnt == 4'hf, "R10 saturates", alias_stall_cnt, 15);
        // R11 ld_ready only when idle
        chk(ld_ready, "R11 ready after response", ld_ready, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule